// File: doc/BRIEF.md
# Configurable Product-Term Logic Cell

This block is one programmable logic cell of the kind tiled across a field-programmable fabric. It takes eighteen logic inputs and builds a set of product terms from them. Each product term is an AND of chosen inputs, each input taken true or inverted. The terms feed OR sums and an XOR stage that drive four data outputs. Each output picks one of two paths. The fast path ORs a fixed group of four terms. The deep path ORs any subset of a shared pool of twenty terms, then XORs the result with a term reserved for that output. A per-output choice then sends either this combinational value or a registered copy of it to the pin.

Three more product terms do control work. One clears the output registers. One can stand in for the global clock. One is exported as an output-enable for the neighbouring I/O logic. The configuration is a wide static vector. It is captured into the cell while a load strobe is high, and it stays fixed during operation. Everything runs from one clock. The alternate clock is realised as a rising-edge-qualified update enable.

Top module: `ptl_cell`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the cell clears all output registers and the edge detector. It also resets the stored configuration to the value where every field is 2'b11. From the next cycle until a new load, `data_o`, `oe_o`, `pt_rst_o` and `pt_clk_o` are all 0.
- R2: Term t occupies bits [t*36 +: 36] of `cfg_terms_i`, and input i of that term uses field bits [2i+1:2i]. The field values are: 2'b00 ignores the input, 2'b01 requires it to be 1, and 2'b10 requires it to be 0. The value 2'b11 forces the whole term to 0. A term is 1 only when every field is met.
- R3: Output j takes its configuration from bits [j*23 +: 23] of `cfg_outs_i`. With bit 2 of that slice set, the combinational value of output j is the OR of terms 4j through 4j+3.
- R4: With bit 2 clear, the combinational value of output j has two parts. The first is the OR of every term k (0 to 19) whose mask bit, bit 3+k of the slice, is set. That OR is then XORed with term 20+j.
- R5: With bit 1 set and bit 0 clear, `data_o[j]` shows a register. The register loads the combinational value at each rising edge where `ce_i` is high, and holds its value otherwise.
- R6: Term 24 is exported on `pt_rst_o`. While it is 1 at a rising edge with `rst_n` high, every output register clears, whatever `ce_i` is.
- R7: With bits 1 and 0 both set, the register of output j loads only at a rising edge where `ce_i` is high, term 25 is 1, and term 25 was 0 at the previous edge.
- R8: `pt_clk_o` shows term 25 and `oe_o` shows term 26, each as a combinational function of `x_i`.
- R9: Configuration is captured at a rising edge only while `cfg_load_i` is high. Changes on `cfg_terms_i` or `cfg_outs_i` at any other time leave the outputs unchanged.
- R10: With bit 1 clear, `data_o[j]` follows `x_i` within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| rst_n | input | 1 | Synchronous active-low global reset |
| ce_i | input | 1 | Register clock-enable |
| x_i | input | 18 | Logic inputs |
| cfg_load_i | input | 1 | Configuration capture strobe |
| cfg_terms_i | input | 972 | Literal fields of the 27 product terms |
| cfg_outs_i | input | 92 | Per-output path, register and clock selection |
| data_o | output | 4 | Cell data outputs |
| oe_o | output | 1 | Output-enable term |
| pt_rst_o | output | 1 | Register-clear term |
| pt_clk_o | output | 1 | Alternate clock term |

## Verification
On every cycle, the checker confirms several things. A global reset leaves the registers clear and the control terms low. A register-clear term empties all four registers at the next edge. The registers hold still when the enable is low and no clear is pending. The stored configuration never moves without the load strobe.

Some behaviour only the bench scenarios can show. These cover the logic function itself: literal decoding, the fast group OR, the masked deep sum and its XOR term. They also cover same-cycle combinational response, and the one-load-per-rising-edge timing of the alternate clock. For these, the bench runs many random configurations and compares every output each cycle against an arithmetic model.

// File: rtl/ptl_pkg.sv
package ptl_pkg;

    localparam int PTL_IN   = 18;
    localparam int PTL_SUM  = 20;
    localparam int PTL_FAST = 4;
    localparam int PTL_OUT  = 4;
    localparam int PTL_CTL  = 3;

    // bit positions inside one output configuration slice
    localparam int OC_PTCLK    = 0;
    localparam int OC_REG      = 1;
    localparam int OC_FAST     = 2;
    localparam int OC_MASK_LSB = 3;

    typedef enum logic [1:0] {
        LIT_ANY   = 2'b00,
        LIT_TRUE  = 2'b01,
        LIT_FALSE = 2'b10,
        LIT_NEVER = 2'b11
    } lit_e;

    typedef struct packed {
        logic oe;
        logic clk;
        logic rst;
    } ctl_pt_t;

endpackage

// File: rtl/ptl_cfg_store.sv
module ptl_cfg_store #(
    parameter int TERM_BITS = 972,
    parameter int OUT_BITS  = 92
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [TERM_BITS-1:0] terms_d_i,
    input  logic [OUT_BITS-1:0]  outs_d_i,
    output logic [TERM_BITS-1:0] terms_q_o,
    output logic [OUT_BITS-1:0]  outs_q_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            terms_q_o <= '1;   // every field forced to never-true
            outs_q_o  <= '0;
        end else if (load_i) begin
            terms_q_o <= terms_d_i;
            outs_q_o  <= outs_d_i;
        end
    end

endmodule

// File: rtl/ptl_term_array.sv
module ptl_term_array
    import ptl_pkg::*;
#(
    parameter int N_IN    = 18,
    parameter int N_TERMS = 27
) (
    input  logic [N_IN-1:0]           x_i,
    input  logic [N_TERMS*2*N_IN-1:0] cfg_i,
    output logic [N_TERMS-1:0]        pt_o
);

    localparam int TW = 2 * N_IN;

    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        logic hit;
        always_comb begin
            hit = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                case (lit_e'(cfg_i[t*TW + 2*i +: 2]))
                    LIT_TRUE:  hit = hit & x_i[i];
                    LIT_FALSE: hit = hit & ~x_i[i];
                    LIT_NEVER: hit = 1'b0;
                    default:   hit = hit;
                endcase
            end
        end
        assign pt_o[t] = hit;
    end

endmodule

// File: rtl/ptl_out_cell.sv
module ptl_out_cell
    import ptl_pkg::*;
#(
    parameter int N_SUM  = 20,
    parameter int N_FAST = 4,
    parameter int IDX    = 0,
    localparam int OW    = N_SUM + OC_MASK_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_i,
    input  logic [N_SUM-1:0] sum_pt_i,
    input  logic             xor_pt_i,
    input  logic             pt_rst_i,
    input  logic             pt_clk_rise_i,
    input  logic [OW-1:0]    cfg_i,
    output logic             dout_o,
    output logic             q_o
);

    logic [N_SUM-1:0] mask;
    logic             fast_v, deep_v, comb_v, tick;

    assign mask   = cfg_i[OC_MASK_LSB +: N_SUM];
    assign fast_v = |sum_pt_i[IDX*N_FAST +: N_FAST];
    assign deep_v = (|(sum_pt_i & mask)) ^ xor_pt_i;
    assign comb_v = cfg_i[OC_FAST] ? fast_v : deep_v;
    assign tick   = ce_i & (cfg_i[OC_PTCLK] ? pt_clk_rise_i : 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n || pt_rst_i) q_o <= 1'b0;
        else if (tick)          q_o <= comb_v;
    end

    assign dout_o = cfg_i[OC_REG] ? q_o : comb_v;

endmodule

// File: rtl/ptl_cell.sv
module ptl_cell
    import ptl_pkg::*;
#(
    parameter int N_IN   = PTL_IN,
    parameter int N_SUM  = PTL_SUM,
    parameter int N_FAST = PTL_FAST,
    parameter int N_OUT  = PTL_OUT,
    localparam int TW      = 2 * N_IN,
    localparam int N_TERMS = N_SUM + N_OUT + PTL_CTL,
    localparam int OW      = N_SUM + OC_MASK_LSB
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce_i,
    input  logic [N_IN-1:0]         x_i,
    input  logic                    cfg_load_i,
    input  logic [N_TERMS*TW-1:0]   cfg_terms_i,
    input  logic [N_OUT*OW-1:0]     cfg_outs_i,
    output logic [N_OUT-1:0]        data_o,
    output logic                    oe_o,
    output logic                    pt_rst_o,
    output logic                    pt_clk_o
);

    localparam int XOR_BASE = N_SUM;
    localparam int RST_T    = N_SUM + N_OUT;
    localparam int CLK_T    = RST_T + 1;
    localparam int OE_T     = RST_T + 2;

    logic [N_TERMS*TW-1:0] cfg_terms_q;
    logic [N_OUT*OW-1:0]   cfg_outs_q;
    logic [N_TERMS-1:0]    pt;
    logic [N_OUT-1:0]      q_all;
    ctl_pt_t               ctl;
    logic                  clk_pt_prev;
    logic                  clk_pt_rise;

    ptl_cfg_store #(.TERM_BITS(N_TERMS*TW), .OUT_BITS(N_OUT*OW)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (cfg_load_i),
        .terms_d_i (cfg_terms_i),
        .outs_d_i  (cfg_outs_i),
        .terms_q_o (cfg_terms_q),
        .outs_q_o  (cfg_outs_q)
    );

    ptl_term_array #(.N_IN(N_IN), .N_TERMS(N_TERMS)) arr_i (
        .x_i   (x_i),
        .cfg_i (cfg_terms_q),
        .pt_o  (pt)
    );

    assign ctl = '{oe: pt[OE_T], clk: pt[CLK_T], rst: pt[RST_T]};

    always_ff @(posedge clk) begin
        if (!rst_n) clk_pt_prev <= 1'b0;
        else        clk_pt_prev <= ctl.clk;
    end
    assign clk_pt_rise = ctl.clk & ~clk_pt_prev;

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        ptl_out_cell #(.N_SUM(N_SUM), .N_FAST(N_FAST), .IDX(j)) cell_i (
            .clk           (clk),
            .rst_n         (rst_n),
            .ce_i          (ce_i),
            .sum_pt_i      (pt[N_SUM-1:0]),
            .xor_pt_i      (pt[XOR_BASE + j]),
            .pt_rst_i      (ctl.rst),
            .pt_clk_rise_i (clk_pt_rise),
            .cfg_i         (cfg_outs_q[j*OW +: OW]),
            .dout_o        (data_o[j]),
            .q_o           (q_all[j])
        );
    end

    assign oe_o     = ctl.oe;
    assign pt_rst_o = ctl.rst;
    assign pt_clk_o = ctl.clk;

endmodule

// File: rtl/ptl_cell_chk.sv
module ptl_cell_chk #(
    parameter int N_OUT  = 4,
    parameter int CFG_W  = 972
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_i,
    input logic             cfg_load_i,
    input logic             oe_o,
    input logic             pt_rst_o,
    input logic             pt_clk_o,
    input logic [N_OUT-1:0] q_all,
    input logic [CFG_W-1:0] cfg_q
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (q_all == '0 && !oe_o && !pt_rst_o && !pt_clk_o));

    assert_term_reset_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pt_rst_o |=> (q_all == '0));

    assert_hold_without_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_i && !pt_rst_o) |=> $stable(q_all));

    assert_cfg_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load_i |=> $stable(cfg_q));

endmodule

bind ptl_cell ptl_cell_chk #(.N_OUT(N_OUT), .CFG_W(N_TERMS*TW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_i       (ce_i),
    .cfg_load_i (cfg_load_i),
    .oe_o       (oe_o),
    .pt_rst_o   (pt_rst_o),
    .pt_clk_o   (pt_clk_o),
    .q_all      (q_all),
    .cfg_q      (cfg_terms_q)
);

// File: tb/ptl_cell_tb_top.sv
module ptl_cell_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NI = 18, NS = 20, NO = 4;
    localparam int NT = NS + NO + 3, TW = 2 * NI, OW = NS + 3;
    localparam int XB = NS, RT = NS + NO, CT = RT + 1, OT = RT + 2;

    logic              clk = 1'b0;
    logic              rst_n, ce, load;
    logic [NI-1:0]     x;
    logic [NT*TW-1:0]  terms_d;
    logic [NO*OW-1:0]  outs_d;
    logic [NO-1:0]     data_o;
    logic              oe_o, pt_rst_o, pt_clk_o;

    int n_chk = 0, n_fail = 0;

    ptl_cell dut_i (
        .clk(clk), .rst_n(rst_n), .ce_i(ce), .x_i(x), .cfg_load_i(load),
        .cfg_terms_i(terms_d), .cfg_outs_i(outs_d), .data_o(data_o),
        .oe_o(oe_o), .pt_rst_o(pt_rst_o), .pt_clk_o(pt_clk_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- requirement model ----------------
    logic [NT*TW-1:0] terms_m;
    logic [NO*OW-1:0] outs_m;
    logic [NO-1:0]    q_m;
    logic             prev_m;

    function automatic bit tv(input logic [NT*TW-1:0] c, input int t, input logic [NI-1:0] v);
        bit r = 1'b1;
        for (int i = 0; i < NI; i++) begin
            case (c[t*TW + 2*i +: 2])
                2'b01: if (!v[i]) r = 1'b0;
                2'b10: if (v[i])  r = 1'b0;
                2'b11: r = 1'b0;
                default: ;
            endcase
        end
        return r;
    endfunction

    function automatic bit cv(input logic [NT*TW-1:0] c, input logic [NO*OW-1:0] o,
                              input int j, input logic [NI-1:0] v);
        bit s = 1'b0;
        if (o[j*OW + 2]) begin
            for (int k = 4*j; k < 4*j + 4; k++) if (tv(c, k, v)) s = 1'b1;
            return s;
        end
        for (int k = 0; k < NS; k++) if (o[j*OW + 3 + k] && tv(c, k, v)) s = 1'b1;
        return s ^ tv(c, XB + j, v);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            terms_m <= '1; outs_m <= '0; q_m <= '0; prev_m <= 1'b0;
        end else begin
            if (load) begin terms_m <= terms_d; outs_m <= outs_d; end
            prev_m <= tv(terms_m, CT, x);
            for (int j = 0; j < NO; j++) begin
                if (tv(terms_m, RT, x)) q_m[j] <= 1'b0;
                else if (ce && (outs_m[j*OW] ? (tv(terms_m, CT, x) && !prev_m) : 1'b1))
                    q_m[j] <= cv(terms_m, outs_m, j, x);
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        for (int j = 0; j < NO; j++) begin
            bit    e;
            string tag;
            if (outs_m[j*OW + 1]) begin
                e = q_m[j];
                tag = outs_m[j*OW] ? "R7" : "R5";
            end else begin
                e = cv(terms_m, outs_m, j, x);
                tag = outs_m[j*OW + 2] ? "R3" : "R4";
            end
            chk(data_o[j] == e, tag, $sformatf("data_o[%0d]", j), int'(data_o[j]), int'(e));
        end
        chk(pt_rst_o == tv(terms_m, RT, x), "R6", "pt_rst_o", int'(pt_rst_o), int'(tv(terms_m, RT, x)));
        chk(pt_clk_o == tv(terms_m, CT, x), "R8", "pt_clk_o", int'(pt_clk_o), int'(tv(terms_m, CT, x)));
        chk(oe_o == tv(terms_m, OT, x), "R8", "oe_o", int'(oe_o), int'(tv(terms_m, OT, x)));
    endtask

    function automatic logic [1:0] rand_lit(input int any_pct);
        int r = int'($urandom % 100);
        if (r < any_pct) return 2'b00;
        if (r < any_pct + (98 - any_pct) / 2) return 2'b01;
        if (r < 98) return 2'b10;
        return 2'b11;
    endfunction

    task automatic rand_cfg();
        for (int t = 0; t < NT; t++)
            for (int i = 0; i < NI; i++)
                terms_d[t*TW + 2*i +: 2] = rand_lit(t == RT ? 70 : 78);
        for (int i = 0; i < NI; i++) terms_d[CT*TW + 2*i +: 2] = 2'b00;
        terms_d[CT*TW + 2*int'($urandom % NI) +: 2] = 2'b01;
        for (int j = 0; j < NO; j++) outs_d[j*OW +: OW] = OW'($urandom);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; ce = 1'b1; load = 1'b0; x = '0;
        terms_d = '1; outs_d = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        x = NI'($urandom);
        #1;
        // R1: reset state, all outputs low whatever the inputs
        chk(data_o == '0, "R1", "data_o", int'(data_o), 0);
        chk({oe_o, pt_rst_o, pt_clk_o} == 3'b000, "R1", "ctl", int'({oe_o, pt_rst_o, pt_clk_o}), 0);

        // R2: term0 = x0 & ~x1; term1 has a never field; out0 on fast path
        @(negedge clk);
        terms_d = '1;
        terms_d[0 +: TW] = '0;
        terms_d[0 +: 2] = 2'b01;
        terms_d[2 +: 2] = 2'b10;
        terms_d[TW +: TW] = '0;
        terms_d[TW + 10 +: 2] = 2'b11;
        outs_d = '0;
        outs_d[2] = 1'b1;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            x = {NI'($urandom) >> 3, 3'(v)};
            #1;
            chk(data_o[0] == (x[0] & ~x[1]), "R2", "literal term", int'(data_o[0]), int'(x[0] & ~x[1]));
        end

        // R10: combinational output tracks input inside one clock phase
        @(negedge clk);
        x[1:0] = 2'b01; #1;
        chk(data_o[0] == 1'b1, "R10", "same-cycle rise", int'(data_o[0]), 1);
        x[1:0] = 2'b11; #1;
        chk(data_o[0] == 1'b0, "R10", "same-cycle fall", int'(data_o[0]), 0);

        // R9: config changed without strobe has no effect
        terms_d[0 +: TW] = '0;
        @(negedge clk);
        @(negedge clk);
        x[1:0] = 2'b10; #1;
        chk(data_o[0] == 1'b0, "R9", "unloaded config", int'(data_o[0]), 0);

        // random configurations, all outputs compared each cycle
        for (int p = 0; p < 40; p++) begin
            @(negedge clk);
            rand_cfg();
            load = 1'b1;
            rst_n = 1'b1;
            x = NI'($urandom);
            #1 check_all();
            for (int c = 0; c < 300; c++) begin
                @(negedge clk);
                load = 1'b0;
                x = NI'($urandom);
                ce = ($urandom % 4) != 0;
                rst_n = ($urandom % 200) != 0;
                terms_d[int'($urandom % NT)*TW +: TW] = TW'({$urandom, $urandom});
                #1 check_all();
            end
        end
        finish_run();
    end

endmodule